// File: doc/BRIEF.md
# Masked Condition-Flag Generator

This block works out the condition-flag word that an integer micro-operation leaves behind. It takes the flag word as it stood before the operation, an update mask, the operation's result, both source operands, and a runtime operand size of 1, 2, 4 or 8 bytes. It derives carry, parity, auxiliary carry, zero, sign and overflow from the result and the operands alone. No carry chain from the adder is used. It also produces a second copy of carry and of zero that the emulation microcode uses. Only the flags whose mask bit is set are rewritten. Every other bit of the 64-bit word passes through unchanged.

The carry and overflow rules are the ones for addition. The size select names a byte count directly. Any other value is flagged as an error and returns the old word untouched. With the default setting the new word and the error bit come out of a register one cycle after the inputs. With the `REG_OUT` parameter cleared they are purely combinational.

Top module: `flag_gen_unit`

## Requirements
- R1: Every bit of `newFlags` whose `updMask` bit is clear equals the corresponding bit of `oldFlags`. A mask bit set at a position that holds no flag also has no effect on that bit.
- R2: A flag whose mask bit is set is written with its freshly computed condition. A stale 1 from `oldFlags` is therefore cleared when the condition is false.
- R3: Carry (bit 0) is `(a&b)|((a|b)&~r)` taken at the top bit of the selected size. `sizeSel` is 1, 2, 4 or 8 bytes, so the top bit is 7, 15, 31 or 63.
- R4: Auxiliary carry (bit 4) is the same expression taken at bit 3, whatever the size.
- R5: Zero (bit 6) is 1 when every result bit below the selected size is 0. Result bits above the size are ignored.
- R6: Sign (bit 7) equals the result bit at the top of the selected size.
- R7: Overflow (bit 11) is `(a^r)&(b^r)` taken at the top bit of the selected size.
- R8: Parity (bit 2) is 1 when result bits 7..0 hold an even number of ones.
- R9: Emulation carry (bit 16) uses the carry condition. Emulation zero (bit 17) uses the zero condition. Each is written only under its own mask bit.
- R10: A `sizeSel` other than 1, 2, 4 or 8 sets `sizeErr` to 1 and makes `newFlags` equal `oldFlags`. For a legal size, `sizeErr` is 0.
- R11: With `REG_OUT`=1, outputs follow the inputs sampled at the previous rising clock edge. While `rstN` is low, `newFlags` and `sizeErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low synchronous reset |
| oldFlags | input | 64 | Flag word before the operation |
| updMask | input | 64 | Set bits select flags to rewrite |
| resVal | input | 64 | Operation result |
| opA | input | 64 | First source operand |
| opB | input | 64 | Second source operand |
| sizeSel | input | 4 | Operand size in bytes: 1, 2, 4 or 8 |
| newFlags | output | 64 | Updated flag word |
| sizeErr | output | 1 | High for an illegal size select |

## Verification
The block holds no state apart from the output register. A wrong size decode or a bad flag-position mapping therefore shows on `newFlags` in the very next cycle. It appears as a flipped flag, as a change in a bit the mask did not select, or as a wrong `sizeErr`. A behavioural model recomputes the whole word for every vector, so any such fault shows up on the first vector that exercises it. Directed vectors push carry, zero and overflow to the edge of each of the four sizes. They also plant stale ones under the mask and set mask bits at non-flag positions, so faults that random data seldom triggers still reach the ports.

// File: rtl/flag_gen_pkg.sv
package flag_gen_pkg;

  localparam int FLAG_W    = 64;
  localparam int DATA_W    = 64;
  localparam int SEL_W     = 4;
  localparam int NUM_SIZES = 4;
  localparam int NUM_FLAGS = 8;

  // flag slots inside the strobe/value vectors
  localparam int IDX_CF  = 0;
  localparam int IDX_PF  = 1;
  localparam int IDX_AF  = 2;
  localparam int IDX_ZF  = 3;
  localparam int IDX_SF  = 4;
  localparam int IDX_OF  = 5;
  localparam int IDX_ECF = 6;
  localparam int IDX_EZF = 7;

  // bit positions in the flag word
  localparam int POS_CF  = 0;
  localparam int POS_PF  = 2;
  localparam int POS_AF  = 4;
  localparam int POS_ZF  = 6;
  localparam int POS_SF  = 7;
  localparam int POS_OF  = 11;
  localparam int POS_ECF = 16;
  localparam int POS_EZF = 17;

  function automatic int flagPos(input int idx);
    case (idx)
      IDX_CF:  return POS_CF;
      IDX_PF:  return POS_PF;
      IDX_AF:  return POS_AF;
      IDX_ZF:  return POS_ZF;
      IDX_SF:  return POS_SF;
      IDX_OF:  return POS_OF;
      IDX_ECF: return POS_ECF;
      IDX_EZF: return POS_EZF;
      default: return POS_CF;
    endcase
  endfunction

  typedef struct packed {
    logic [NUM_SIZES-1:0] sizeHot;  // one-hot: 1, 2, 4, 8 bytes
    logic                 illegal;  // no legal size selected
    logic [NUM_FLAGS-1:0] flagWe;   // per-flag write strobes
  } ctrlStrobes_t;

endpackage

// File: rtl/flag_gen_ctrl.sv
module flag_gen_ctrl
  import flag_gen_pkg::*;
#(
  parameter int SelW     = SEL_W,
  parameter int NumSizes = NUM_SIZES,
  parameter int NumFlags = NUM_FLAGS
) (
  input  logic [SelW-1:0]     sizeSel,
  input  logic [NumFlags-1:0] flagMask,
  output ctrlStrobes_t        strobes
);

  logic [NumSizes-1:0] sizeHot;

  genvar gi;
  generate
    for (gi = 0; gi < NumSizes; gi++) begin : gSizeDec
      localparam logic [SelW-1:0] BYTES = SelW'(1 << gi);
      assign sizeHot[gi] = (sizeSel == BYTES);
    end
  endgenerate

  always_comb begin
    strobes.sizeHot = sizeHot;
    strobes.illegal = ~|sizeHot;
    strobes.flagWe  = flagMask;
  end

endmodule

// File: rtl/flag_gen_datapath.sv
module flag_gen_datapath
  import flag_gen_pkg::*;
#(
  parameter int FlagW    = FLAG_W,
  parameter int DataW    = DATA_W,
  parameter int NumSizes = NUM_SIZES,
  parameter int NumFlags = NUM_FLAGS
) (
  input  ctrlStrobes_t     strobes,
  input  logic [FlagW-1:0] oldFlags,
  input  logic [DataW-1:0] resVal,
  input  logic [DataW-1:0] opA,
  input  logic [DataW-1:0] opB,
  output logic [FlagW-1:0] nextFlags
);

  logic [NumSizes-1:0] carryAt;
  logic [NumSizes-1:0] ovAt;
  logic [NumSizes-1:0] signAt;
  logic [NumSizes-1:0] zeroAt;
  logic [NumFlags-1:0] flagVal;
  logic                cfVal;
  logic                zfVal;

  genvar gi;
  generate
    for (gi = 0; gi < NumSizes; gi++) begin : gSize
      localparam int TOP = (8 << gi) - 1;
      assign carryAt[gi] = (opA[TOP] & opB[TOP]) |
                           ((opA[TOP] | opB[TOP]) & ~resVal[TOP]);
      assign ovAt[gi]    = (opA[TOP] ^ resVal[TOP]) & (opB[TOP] ^ resVal[TOP]);
      assign signAt[gi]  = resVal[TOP];
      assign zeroAt[gi]  = ~|resVal[TOP:0];
    end
  endgenerate

  assign cfVal = |(carryAt & strobes.sizeHot);
  assign zfVal = |(zeroAt & strobes.sizeHot);

  always_comb begin
    flagVal          = '0;
    flagVal[IDX_CF]  = cfVal;
    flagVal[IDX_PF]  = ~^resVal[7:0];
    flagVal[IDX_AF]  = (opA[3] & opB[3]) | ((opA[3] | opB[3]) & ~resVal[3]);
    flagVal[IDX_ZF]  = zfVal;
    flagVal[IDX_SF]  = |(signAt & strobes.sizeHot);
    flagVal[IDX_OF]  = |(ovAt & strobes.sizeHot);
    flagVal[IDX_ECF] = cfVal;
    flagVal[IDX_EZF] = zfVal;
  end

  always_comb begin
    nextFlags = oldFlags;
    if (!strobes.illegal) begin
      for (int k = 0; k < NumFlags; k++) begin
        if (strobes.flagWe[k]) nextFlags[flagPos(k)] = flagVal[k];
      end
    end
  end

endmodule

// File: rtl/flag_gen_unit.sv
module flag_gen_unit
  import flag_gen_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FLAG_W-1:0] oldFlags,
  input  logic [FLAG_W-1:0] updMask,
  input  logic [DATA_W-1:0] resVal,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [SEL_W-1:0]  sizeSel,
  output logic [FLAG_W-1:0] newFlags,
  output logic              sizeErr
);

  ctrlStrobes_t         strobes;
  logic [NUM_FLAGS-1:0] flagMask;
  logic [FLAG_W-1:0]    nextFlags;

  genvar gk;
  generate
    for (gk = 0; gk < NUM_FLAGS; gk++) begin : gMaskPick
      assign flagMask[gk] = updMask[flagPos(gk)];
    end
  endgenerate

  flag_gen_ctrl u_ctrl (
    .sizeSel  (sizeSel),
    .flagMask (flagMask),
    .strobes  (strobes)
  );

  flag_gen_datapath u_dp (
    .strobes   (strobes),
    .oldFlags  (oldFlags),
    .resVal    (resVal),
    .opA       (opA),
    .opB       (opB),
    .nextFlags (nextFlags)
  );

  generate
    if (REG_OUT) begin : gReg
      logic liveQ;

      always_ff @(posedge clk) begin
        if (!rstN) begin
          newFlags <= '0;
          sizeErr  <= 1'b0;
          liveQ    <= 1'b0;
        end else begin
          newFlags <= nextFlags;
          sizeErr  <= strobes.illegal;
          liveQ    <= 1'b1;
        end
      end

      AST_UNMASKED_PASS: assert property (@(posedge clk) disable iff (!rstN)
        liveQ |-> (((newFlags ^ $past(oldFlags)) & ~$past(updMask)) == '0)); // R1
      AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
        (liveQ && sizeErr) |-> (newFlags == $past(oldFlags))); // R10
      AST_ERR_ON_BAD_SIZE: assert property (@(posedge clk) disable iff (!rstN)
        liveQ |-> (sizeErr == !($past(sizeSel) == 4'd1 || $past(sizeSel) == 4'd2 ||
                                $past(sizeSel) == 4'd4 || $past(sizeSel) == 4'd8))); // R10
      AST_ECF_TRACKS_CF: assert property (@(posedge clk) disable iff (!rstN)
        (liveQ && !sizeErr && $past(updMask[POS_CF]) && $past(updMask[POS_ECF]))
          |-> (newFlags[POS_ECF] == newFlags[POS_CF])); // R9
      AST_EZF_TRACKS_ZF: assert property (@(posedge clk) disable iff (!rstN)
        (liveQ && !sizeErr && $past(updMask[POS_ZF]) && $past(updMask[POS_EZF]))
          |-> (newFlags[POS_EZF] == newFlags[POS_ZF])); // R9
      AST_SIGN_QWORD: assert property (@(posedge clk) disable iff (!rstN)
        (liveQ && $past(updMask[POS_SF]) && ($past(sizeSel) == 4'd8))
          |-> (newFlags[POS_SF] == $past(resVal[DATA_W-1]))); // R6
    end else begin : gComb
      assign newFlags = nextFlags;
      assign sizeErr  = strobes.illegal;

      AST_COMB_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
        (((newFlags ^ oldFlags) & ~updMask) == '0)); // R1
      AST_COMB_ILLEGAL: assert property (@(posedge clk) disable iff (!rstN)
        sizeErr |-> (newFlags == oldFlags)); // R10
    end
  endgenerate

endmodule

// File: tb/flag_gen_unit_tb.sv
module flag_gen_unit_tb;

  localparam logic [63:0] ALL_FLAGS = 64'h0000_0000_0003_08D5;

  logic        clk = 1'b0;
  logic        rstN;
  logic [63:0] oldFlags, updMask, resVal, opA, opB;
  logic [3:0]  sizeSel;
  logic [63:0] newFlags;
  logic        sizeErr;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  logic [63:0] lastExpF;
  logic        lastExpE;

  always #5 clk = ~clk;

  flag_gen_unit u_dut (
    .clk(clk), .rstN(rstN), .oldFlags(oldFlags), .updMask(updMask),
    .resVal(resVal), .opA(opA), .opB(opB), .sizeSel(sizeSel),
    .newFlags(newFlags), .sizeErr(sizeErr)
  );

  function automatic void refModel(input logic [63:0] old, input logic [63:0] mask,
                                   input logic [63:0] r, input logic [63:0] a,
                                   input logic [63:0] b, input logic [3:0] sz,
                                   output logic [63:0] f, output logic e);
    int n, ones;
    logic cf, af, zf, sf, of, pf;
    e = !(sz == 1 || sz == 2 || sz == 4 || sz == 8);
    f = old;
    if (e) return;
    n  = int'(sz) * 8;
    cf = (a[n-1] & b[n-1]) | ((a[n-1] | b[n-1]) & ~r[n-1]);
    af = (a[3] & b[3]) | ((a[3] | b[3]) & ~r[3]);
    of = (a[n-1] ^ r[n-1]) & (b[n-1] ^ r[n-1]);
    sf = r[n-1];
    zf = 1'b1;
    for (int i = 0; i < n; i++) if (r[i]) zf = 1'b0;
    ones = 0;
    for (int i = 0; i < 8; i++) if (r[i]) ones++;
    pf = (ones % 2) == 0;
    if (mask[0])  f[0]  = cf;
    if (mask[2])  f[2]  = pf;
    if (mask[4])  f[4]  = af;
    if (mask[6])  f[6]  = zf;
    if (mask[7])  f[7]  = sf;
    if (mask[11]) f[11] = of;
    if (mask[16]) f[16] = cf;
    if (mask[17]) f[17] = zf;
  endfunction

  task automatic compare(input string tag, input logic [63:0] expF, input logic expE);
    checkCnt++;
    if (newFlags !== expF || sizeErr !== expE) begin
      failCnt++;
      $display("FAIL %s: flags=%h err=%b expected flags=%h err=%b",
               tag, newFlags, sizeErr, expF, expE);
    end
  endtask

  task automatic apply(input string tag, input logic [63:0] old, input logic [63:0] mask,
                       input logic [63:0] r, input logic [63:0] a, input logic [63:0] b,
                       input logic [3:0] sz);
    logic [63:0] expF;
    logic        expE;
    @(negedge clk);
    oldFlags = old; updMask = mask; resVal = r; opA = a; opB = b; sizeSel = sz;
    refModel(old, mask, r, a, b, sz, expF, expE);
    @(posedge clk);
    #1;
    compare(tag, expF, expE);
    lastExpF = expF;
    lastExpE = expE;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    oldFlags = '1; updMask = '1; resVal = '0; opA = '1; opB = '1; sizeSel = 4'd1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R11 reset state", 64'h0, 1'b0);
    rstN = 1'b1;

    // carry at each size (R3)
    apply("R3 byte carry",  64'h0, ALL_FLAGS, 64'h00, 64'hFF, 64'h01, 4'd1);
    apply("R3 word carry",  64'h0, ALL_FLAGS, 64'h1_0000, 64'hFFFF, 64'h1, 4'd2);
    apply("R3 dword carry", 64'h0, ALL_FLAGS, 64'h0, 64'hFFFF_FFFF, 64'h1, 4'd4);
    apply("R3 qword carry", 64'h0, ALL_FLAGS, 64'h0, '1, 64'h1, 4'd8);
    apply("R3 byte no carry", 64'h0, ALL_FLAGS, 64'h7F, 64'h7E, 64'h01, 4'd1);
    // zero ignores upper bits (R5)
    apply("R5 zero ignores upper", 64'h0, ALL_FLAGS, 64'h100, 64'h80, 64'h80, 4'd1);
    apply("R5 zero word nonzero",  64'h0, ALL_FLAGS, 64'h100, 64'h80, 64'h80, 4'd2);
    // sign and overflow (R6, R7)
    apply("R7 byte overflow", 64'h0, ALL_FLAGS, 64'h80, 64'h7F, 64'h01, 4'd1);
    apply("R6 sign dword",    64'h0, ALL_FLAGS, 64'h8000_0000, 64'h7FFF_FFFF, 64'h1, 4'd4);
    apply("R7 qword overflow", 64'h0, ALL_FLAGS, 64'h8000_0000_0000_0000,
          64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 4'd8);
    // parity (R8)
    apply("R8 parity even", 64'h0, ALL_FLAGS, 64'h03, 64'h01, 64'h02, 4'd1);
    apply("R8 parity odd",  64'h0, ALL_FLAGS, 64'hF07, 64'h01, 64'h06, 4'd2);
    // auxiliary carry (R4)
    apply("R4 aux carry", 64'h0, ALL_FLAGS, 64'h10, 64'h0F, 64'h01, 4'd8);
    // stale ones cleared (R2)
    apply("R2 stale cleared", '1, ALL_FLAGS, 64'h01, 64'h00, 64'h01, 4'd1);
    // unmasked and non-flag mask bits (R1)
    apply("R1 empty mask", 64'hA5A5_5A5A_F0F0_0F0F, 64'h0, 64'h0, '1, 64'h1, 4'd1);
    apply("R1 nonflag mask", 64'h1234_5678_9ABC_DEF0, ~ALL_FLAGS, 64'h0, '1, 64'h1, 4'd8);
    // emulation copies under their own mask bits (R9)
    apply("R9 emulation only", 64'h0, 64'h3_0000, 64'h0, 64'hFF, 64'h1, 4'd1);
    apply("R9 ecf alone", 64'h2_0000, 64'h1_0000, 64'h5, 64'hFF, 64'h6, 4'd1);
    // illegal sizes (R10)
    foreach (sizeSel[i]) begin end
    for (int s = 0; s < 16; s++) begin
      if (s != 1 && s != 2 && s != 4 && s != 8)
        apply("R10 illegal size", 64'hDEAD_BEEF_0BAD_F00D, '1, 64'h0, '1, 64'h1, 4'(s));
    end
    // latency (R11): output holds previous result until the next edge
    @(negedge clk);
    oldFlags = 64'h0; updMask = ALL_FLAGS; resVal = 64'h0; opA = '1; opB = 64'h1;
    sizeSel = 4'd1;
    #1;
    compare("R11 latency hold", lastExpF, lastExpE);
    // random vectors (R2)
    for (int v = 0; v < 400; v++) begin
      logic [3:0] sz;
      case ($urandom % 5)
        0: sz = 4'd1;
        1: sz = 4'd2;
        2: sz = 4'd4;
        3: sz = 4'd8;
        default: sz = 4'($urandom);
      endcase
      apply("R2 random", {$urandom, $urandom}, {$urandom, $urandom},
            {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom}, sz);
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule